// File: doc/BRIEF.md
# Auto-Sequencing Colour Lookup Table

This block is a 256-entry colour palette for a display pipeline. Each entry holds a red, a green and a blue component of 4 bits. Software reaches the whole table through two byte-wide registers. The first is an index register. The second is a data register that takes, or returns, the three components of one entry one after another. The display side has its own port: it presents a pixel index every cycle and gets back the stored colour triple one cycle later.

A small phase counter steps through red, green and blue on every data access. Red and green are held in staging registers. The table is updated only when blue arrives, so the display never sees a partly loaded entry. After each complete triple the index advances by one and the phase goes back to red. Software can therefore stream a whole palette with a single index write, followed by back-to-back data writes or reads.

Top module: `clut_top`

## Requirements
- R1: After reset the index is 0, the phase is red, every table entry is zero, `hostRdata` is 0x00 and `pixRgb` is 0x000.
- R2: A write to the index register (`hostAddrWe`) loads `hostWdata` as the entry index and returns the phase to red. A red or green component already staged is then never committed by itself: the next three data writes load the newly chosen entry.
- R3: Three data writes (`hostDataWe`) carry red, then green, then blue. Each component is stored as bits [7:4] of `hostWdata`, and bits [3:0] are ignored. An entry is seen on `pixRgb` as {red[11:8], green[7:4], blue[3:0]}.
- R4: The table entry changes only on the blue write. After the red and green writes alone, a lookup of that index still returns the old contents.
- R5: After the third access of a triple (write or read), the index increases by one and the phase returns to red. Index 255 wraps to 0.
- R6: A data read (`hostDataRe`) returns the component for the current phase as {component, 4'b0000} on `hostRdata` one cycle later, in red, green, blue order. It advances the same phase counter. `hostRdata` holds its value when no read occurs.
- R7: `pixRgb` shows the entry selected by `pixIdx` one clock after `pixIdx` is sampled, independent of host activity. An entry committed at a clock edge is visible from the next lookup.
- R8: When `hostAddrWe` is high, a data write or read in the same cycle is ignored.
- R9: When `hostDataWe` and `hostDataRe` are both high, the write is performed and the read is ignored: `hostRdata` keeps its value and the phase advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddrWe | input | 1 | Write `hostWdata` to the index register |
| hostDataWe | input | 1 | Write one colour component through the data register |
| hostDataRe | input | 1 | Read one colour component through the data register |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, component in bits [7:4] |
| pixIdx | input | 8 | Pixel lookup index |
| pixRgb | output | 12 | Looked-up colour {R, G, B} |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. A data read shows on `hostRdata` at the edge that takes the read. A pixel index shows its entry on `pixRgb` at the next edge. A blue write makes its entry visible to lookups that sample after its commit edge. The bench changes inputs on the falling edge and samples on the following falling edge, half a period after the one rising edge that produces the result. For a blue write it waits one extra cycle before checking the lookup, so every check lands on the single cycle where the value first becomes valid.

// File: rtl/clut_pkg.sv
package clut_pkg;

  // Component phase of the shared data register
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   stRed;   // stage red component
    logic   stGrn;   // stage green component
    logic   commit;  // blue arrived: write whole entry
    logic   rdEn;    // host read of one component
    phase_e phase;   // component selected for the read
  } strobe_t;

endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostAddrWe,
  input  logic             hostDataWe,
  input  logic             hostDataRe,
  input  logic [IDX_W-1:0] addrIn,
  output strobe_t          strb,
  output logic [IDX_W-1:0] idx
);

  phase_e           phaseQ;
  logic [IDX_W-1:0] addrQ;
  logic             wrOp;
  logic             rdOp;
  logic             dataOp;

  // The index write wins over data accesses, and a data write wins over a read.
  assign wrOp   = hostDataWe & ~hostAddrWe;
  assign rdOp   = hostDataRe & ~hostDataWe & ~hostAddrWe;
  assign dataOp = wrOp | rdOp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      phaseQ <= PH_RED;
    end else if (hostAddrWe) begin
      addrQ  <= addrIn;
      phaseQ <= PH_RED;
    end else if (dataOp) begin
      unique case (phaseQ)
        PH_RED:  phaseQ <= PH_GRN;
        PH_GRN:  phaseQ <= PH_BLU;
        PH_BLU: begin
          phaseQ <= PH_RED;
          addrQ  <= addrQ + 1'b1;
        end
        default: phaseQ <= PH_RED;
      endcase
    end
  end

  always_comb begin
    strb.stRed  = wrOp & (phaseQ == PH_RED);
    strb.stGrn  = wrOp & (phaseQ == PH_GRN);
    strb.commit = wrOp & (phaseQ == PH_BLU);
    strb.rdEn   = rdOp;
    strb.phase  = phaseQ;
  end

  assign idx = addrQ;

  // R2
  addr_wr_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAddrWe |=> (phaseQ == PH_RED) && (addrQ == $past(addrIn)));

  // R5
  auto_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOp && phaseQ == PH_BLU) |=> (phaseQ == PH_RED) && (addrQ == IDX_W'($past(addrQ) + 1'b1)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostAddrWe && !hostDataWe && !hostDataRe) |=> $stable(phaseQ) && $stable(addrQ));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.stRed, strb.stGrn, strb.commit, strb.rdEn}));

endmodule

// File: rtl/clut_datapath.sv
module clut_datapath
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DATA_W-1:0]   hostWdata,
  output logic [DATA_W-1:0]   hostRdata,
  input  logic [IDX_W-1:0]    pixIdx,
  output logic [3*COMP_W-1:0] pixRgb
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = 3 * COMP_W;
  localparam int PAD_W = DATA_W - COMP_W;

  logic [ENT_W-1:0]  table_q [DEPTH];
  logic [COMP_W-1:0] redQ;
  logic [COMP_W-1:0] grnQ;
  logic [COMP_W-1:0] inComp;
  logic [ENT_W-1:0]  hostEnt;
  logic [COMP_W-1:0] rdComp;

  // Only the upper bits of the written byte are kept.
  assign inComp  = hostWdata[DATA_W-1 -: COMP_W];
  assign hostEnt = table_q[idx];

  always_comb begin
    unique case (strb.phase)
      PH_RED:  rdComp = hostEnt[3*COMP_W-1 -: COMP_W];
      PH_GRN:  rdComp = hostEnt[2*COMP_W-1 -: COMP_W];
      default: rdComp = hostEnt[COMP_W-1 -: COMP_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redQ <= '0;
      grnQ <= '0;
    end else begin
      if (strb.stRed) redQ <= inComp;
      if (strb.stGrn) grnQ <= inComp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) table_q[i] <= '0;
    end else if (strb.commit) begin
      table_q[idx] <= {redQ, grnQ, inComp};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdata <= '0;
    end else if (strb.rdEn) begin
      hostRdata <= {rdComp, {PAD_W{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixRgb <= '0;
    else       pixRgb <= table_q[pixIdx];
  end

  // R6
  rd_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> (hostRdata[PAD_W-1:0] == '0));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(hostRdata));

  // R4
  stage_red_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> $stable(redQ) && $stable(grnQ));

endmodule

// File: rtl/clut_top.sv
module clut_top
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostAddrWe,
  input  logic                hostDataWe,
  input  logic                hostDataRe,
  input  logic [DATA_W-1:0]   hostWdata,
  output logic [DATA_W-1:0]   hostRdata,
  input  logic [IDX_W-1:0]    pixIdx,
  output logic [3*COMP_W-1:0] pixRgb
);

  strobe_t          strb;
  logic [IDX_W-1:0] idx;

  clut_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddrWe (hostAddrWe),
    .hostDataWe (hostDataWe),
    .hostDataRe (hostDataRe),
    .addrIn     (hostWdata[IDX_W-1:0]),
    .strb       (strb),
    .idx        (idx)
  );

  clut_datapath #(.IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .idx       (idx),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .pixIdx    (pixIdx),
    .pixRgb    (pixRgb)
  );

endmodule

// File: tb/clut_top_bench.sv
module clut_top_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostAddrWe, hostDataWe, hostDataRe;
  logic [7:0]  hostWdata;
  logic [7:0]  hostRdata;
  logic [7:0]  pixIdx;
  logic [11:0] pixRgb;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  clut_top u_clut_top (
    .clk(clk), .rstN(rstN),
    .hostAddrWe(hostAddrWe), .hostDataWe(hostDataWe), .hostDataRe(hostDataRe),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .pixIdx(pixIdx), .pixRgb(pixRgb)
  );

  task automatic check(input logic [11:0] act, input logic [11:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
    end
  endtask

  task automatic idle();
    hostAddrWe = 0; hostDataWe = 0; hostDataRe = 0;
  endtask

  task automatic setAddr(input logic [7:0] a);
    @(negedge clk); idle(); hostAddrWe = 1; hostWdata = a;
    @(negedge clk); idle();
  endtask

  task automatic wrData(input logic [7:0] d);
    @(negedge clk); idle(); hostDataWe = 1; hostWdata = d;
    @(negedge clk); idle();
  endtask

  task automatic rdData(output logic [7:0] d);
    @(negedge clk); idle(); hostDataRe = 1;
    @(negedge clk); idle(); d = hostRdata;
  endtask

  task automatic lookup(input logic [7:0] i, output logic [11:0] rgb);
    @(negedge clk); pixIdx = i;
    @(negedge clk); rgb = pixRgb;
  endtask

  task automatic testReset();
    logic [11:0] v;
    check({4'h0, hostRdata}, 12'h000, "R1 hostRdata after reset");
    check(pixRgb, 12'h000, "R1 pixRgb after reset");
    lookup(8'hFF, v); check(v, 12'h000, "R1 entry 255 zero");
  endtask

  task automatic testStream();
    logic [11:0] v;
    setAddr(8'h05);
    wrData(8'h1F); wrData(8'h2E); wrData(8'h3D);
    wrData(8'h4C); wrData(8'h5B); wrData(8'h6A);
    lookup(8'h05, v); check(v, 12'h123, "R3 entry 5, low nibbles ignored");
    lookup(8'h06, v); check(v, 12'h456, "R5 auto-increment to entry 6");
  endtask

  task automatic testAtomic();
    logic [11:0] v;
    setAddr(8'h40);
    wrData(8'hA0); wrData(8'hB0);
    lookup(8'h40, v); check(v, 12'h000, "R4 no update before blue");
    wrData(8'hC0);
    lookup(8'h40, v); check(v, 12'hABC, "R4 committed on blue");
  endtask

  task automatic testReAddr();
    logic [11:0] v;
    setAddr(8'h50);
    wrData(8'h10); wrData(8'h20);
    setAddr(8'h50);
    wrData(8'hD0); wrData(8'hE0); wrData(8'hF0);
    lookup(8'h50, v); check(v, 12'hDEF, "R2 index write restarts at red");
    lookup(8'h51, v); check(v, 12'h000, "R2 no stray commit to next entry");
  endtask

  task automatic testWrap();
    logic [11:0] v;
    setAddr(8'hFF);
    wrData(8'h70); wrData(8'h80); wrData(8'h90);
    wrData(8'h30); wrData(8'h20); wrData(8'h10);
    lookup(8'hFF, v); check(v, 12'h789, "R5 entry 255");
    lookup(8'h00, v); check(v, 12'h321, "R5 wrap to entry 0");
  endtask

  task automatic testRead();
    logic [7:0] d;
    setAddr(8'h05);
    rdData(d); check({4'h0, d}, 12'h010, "R6 read red entry 5");
    rdData(d); check({4'h0, d}, 12'h020, "R6 read green entry 5");
    rdData(d); check({4'h0, d}, 12'h030, "R6 read blue entry 5");
    rdData(d); check({4'h0, d}, 12'h040, "R6 read red entry 6 after increment");
    @(negedge clk); check({4'h0, hostRdata}, 12'h040, "R6 hostRdata holds");
  endtask

  task automatic testPixel();
    logic [11:0] v;
    @(negedge clk); pixIdx = 8'h05;
    @(negedge clk); check(pixRgb, 12'h123, "R7 lookup 5 one cycle");
    pixIdx = 8'h06;
    @(negedge clk); check(pixRgb, 12'h456, "R7 lookup 6 one cycle");
    pixIdx = 8'h40;
    @(negedge clk); check(pixRgb, 12'hABC, "R7 lookup 0x40 one cycle");
    // Lookup while the host streams an update of the same entry
    setAddr(8'h06);
    @(negedge clk); pixIdx = 8'h06; hostDataWe = 1; hostWdata = 8'hE0;
    @(negedge clk); check(pixRgb, 12'h456, "R7 lookup during host write");
    hostWdata = 8'hD0;
    @(negedge clk); hostWdata = 8'hC0;
    @(negedge clk); idle(); check(pixRgb, 12'h456, "R7 old value at commit edge");
    @(negedge clk); check(pixRgb, 12'hEDC, "R7 new value next cycle");
    lookup(8'h06, v);
  endtask

  task automatic testAddrPriority();
    logic [11:0] v;
    @(negedge clk); idle(); hostAddrWe = 1; hostDataWe = 1; hostWdata = 8'h30;
    @(negedge clk); idle();
    wrData(8'h10); wrData(8'h20); wrData(8'h30);
    lookup(8'h30, v); check(v, 12'h123, "R8 data write ignored with index write");
    @(negedge clk); idle(); hostAddrWe = 1; hostDataRe = 1; hostWdata = 8'h30;
    @(negedge clk); idle();
    check({4'h0, hostRdata}, 12'h040, "R8 read ignored with index write");
  endtask

  task automatic testWrPriority();
    logic [11:0] v;
    logic [7:0] d;
    setAddr(8'h30);
    rdData(d); check({4'h0, d}, 12'h010, "R9 read red of 0x30");
    setAddr(8'h30);
    @(negedge clk); idle(); hostDataWe = 1; hostDataRe = 1; hostWdata = 8'h90;
    @(negedge clk); idle();
    check({4'h0, hostRdata}, 12'h010, "R9 read ignored during write");
    wrData(8'h80); wrData(8'h70);
    lookup(8'h30, v); check(v, 12'h987, "R9 write performed");
  endtask

  initial begin
    idle(); hostWdata = 0; pixIdx = 0; rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testStream();
    testAtomic();
    testReAddr();
    testWrap();
    testRead();
    testPixel();
    testAddrPriority();
    testWrPriority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule